// File: doc/BRIEF.md
# Microprogrammed Memory-Copy Processor

This block is a small multi-cycle processor whose sequencing comes from a control store instead of a hand-coded state machine. A control address register selects one microinstruction per clock. Each microinstruction carries a set of datapath strobes and a next-address rule. The rule either increments the register, jumps to a stored target, or dispatches on the opcode of a newly accepted instruction.

The host presents a 16-bit instruction and pulses `start` while `ready` is high. The core then runs the microprogram for that opcode against an external RAM. The RAM has a 4-bit address, returns read data combinationally in the same cycle, and writes on the clock edge while `memWe` is high. The only opcode with a microprogram is the copy, opcode 2, which moves RAM word M[B] into RAM word M[A]. Every microprogram ends by jumping back to the idle microaddress 0.

Top module: `ucopy_cpu`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `ready` is 1, `memWe` is 0 and `memAddr` is 0.
- R2: The instruction is split as follows: opcode in bits 15:12, field A in bits 11:8, field B in bits 7:4 and field C in bits 3:0. Field C is unused by the copy.
- R3: If `start` is high with opcode 2 at a clock edge where `ready` is 1, `ready` is 0 for exactly the next 4 cycles and then returns to 1.
- R4: In the 2nd busy cycle of a copy, `memAddr` equals field B and `memWe` is 0.
- R5: In the 4th busy cycle of a copy, `memAddr` equals field A, `memWdata` equals the word read from M[B], and `memWe` is 1. `memWe` is high for exactly that one cycle.
- R6: For any opcode other than 2, `start` leaves `ready` at 1 and no write occurs.
- R7: The instruction is captured at the accepting edge. Changes to `instrIn` during the microprogram have no effect.
- R8: `start` is ignored while `ready` is 0. It causes no extra write and does not lengthen the program.
- R9: A `start` in the first cycle that `ready` is back at 1 is accepted, so copies can run back to back.
- R10: Asserting `rst` mid-program clears the control address to idle. `ready` returns to 1 and the pending write never happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears the control address register |
| start | input | 1 | Accept the instruction on `instrIn` when `ready` is high |
| instrIn | input | 16 | Instruction word |
| ready | output | 1 | High while idle at microaddress 0 |
| memAddr | output | 4 | RAM address (driven from R0 during access steps, else 0) |
| memRdata | input | 16 | RAM read data, valid in the same cycle as the address |
| memWdata | output | 16 | RAM write data (R1 during the write step, else 0) |
| memWe | output | 1 | RAM write enable |

## Verification
The checker watches every clock edge for four rules:
- `memWe` never stays high for two consecutive cycles.
- A write is always preceded by three busy cycles and followed by idle.
- Accepting a copy drops `ready` on the next cycle.
- Accepting any other opcode keeps `ready` high.

Properties at the ports cannot show the following, so the bench scenarios cover them:
- The write lands at field A and carries the word read from field B.
- A garbled `instrIn` or a stray `start` mid-program changes nothing.
- A reset mid-program aborts the copy.

// File: rtl/ucopy_pkg.sv
package ucopy_pkg;
  typedef struct packed {
    logic capInstr;
    logic ldR0;
    logic r0FromA;
    logic ldR1;
    logic drvAddr;
    logic writeEn;
  } dpStrobes_t;

  typedef enum logic [1:0] {
    NX_DISPATCH = 2'd0,
    NX_INC      = 2'd1,
    NX_JUMP     = 2'd2
  } nxMode_t;

  localparam logic [3:0] OPC_COPY = 4'h2;
endpackage

// File: rtl/ucopy_ctrl.sv
module ucopy_ctrl
  import ucopy_pkg::*;
#(
  parameter int CAR_W = 4,
  parameter int OPC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  output dpStrobes_t       strobes,
  output logic             ready
);
  localparam logic [CAR_W-1:0] IDLE_ADDR  = '0;
  localparam logic [CAR_W-1:0] COPY_ENTRY = CAR_W'(1);

  typedef struct packed {
    logic             isIdle;
    logic             ldR0;
    logic             r0FromA;
    logic             ldR1;
    logic             drvAddr;
    logic             writeEn;
    nxMode_t          mode;
    logic [CAR_W-1:0] target;
  } uword_t;

  // Control store: one microinstruction per control address.
  function automatic uword_t romWord(input logic [CAR_W-1:0] a);
    uword_t w;
    w = '{isIdle: 1'b0, ldR0: 1'b0, r0FromA: 1'b0, ldR1: 1'b0,
          drvAddr: 1'b0, writeEn: 1'b0, mode: NX_JUMP, target: IDLE_ADDR};
    case (a)
      CAR_W'(0): begin w.isIdle = 1'b1; w.mode = NX_DISPATCH; end
      CAR_W'(1): begin w.ldR0 = 1'b1; w.mode = NX_INC; end          // R0 <- B
      CAR_W'(2): begin w.drvAddr = 1'b1; w.ldR1 = 1'b1; w.mode = NX_INC; end
      CAR_W'(3): begin w.ldR0 = 1'b1; w.r0FromA = 1'b1; w.mode = NX_INC; end
      CAR_W'(4): begin w.drvAddr = 1'b1; w.writeEn = 1'b1; w.mode = NX_JUMP; end
      default: ;
    endcase
    return w;
  endfunction

  logic [CAR_W-1:0] car;
  logic [CAR_W-1:0] carNext;
  uword_t           uw;
  logic             accept;

  assign uw     = romWord(car);
  assign accept = uw.isIdle && start;

  always_comb begin
    unique case (uw.mode)
      NX_DISPATCH: carNext = (accept && opcode == OPC_W'(OPC_COPY)) ? COPY_ENTRY : IDLE_ADDR;
      NX_INC:      carNext = car + CAR_W'(1);
      default:     carNext = uw.target;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) car <= IDLE_ADDR;
    else     car <= carNext;
  end

  assign ready            = uw.isIdle;
  assign strobes.capInstr = accept;
  assign strobes.ldR0     = uw.ldR0;
  assign strobes.r0FromA  = uw.r0FromA;
  assign strobes.ldR1     = uw.ldR1;
  assign strobes.drvAddr  = uw.drvAddr;
  assign strobes.writeEn  = uw.writeEn;
endmodule

// File: rtl/ucopy_dp.sv
module ucopy_dp
  import ucopy_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int OPC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobes_t        strobes,
  input  logic [OPC_W+3*ADDR_W-1:0] instrIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe
);
  localparam int INSTR_W = OPC_W + 3 * ADDR_W;
  localparam int A_LSB   = 2 * ADDR_W;
  localparam int B_LSB   = ADDR_W;

  logic [INSTR_W-1:0] instrReg;
  logic [ADDR_W-1:0]  r0;
  logic [DATA_W-1:0]  r1;
  logic [ADDR_W-1:0]  fieldA;
  logic [ADDR_W-1:0]  fieldB;

  assign fieldA = instrReg[A_LSB +: ADDR_W];
  assign fieldB = instrReg[B_LSB +: ADDR_W];
  // Dispatch uses the live opcode so the first microaddress is chosen at the accepting edge.
  assign opcode = instrIn[INSTR_W-1 -: OPC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      instrReg <= '0;
      r0       <= '0;
      r1       <= '0;
    end else begin
      if (strobes.capInstr) instrReg <= instrIn;
      if (strobes.ldR0)     r0 <= strobes.r0FromA ? fieldA : fieldB;
      if (strobes.ldR1)     r1 <= memRdata;
    end
  end

  assign memAddr  = strobes.drvAddr ? r0 : '0;
  assign memWdata = strobes.writeEn ? r1 : '0;
  assign memWe    = strobes.writeEn;
endmodule

// File: rtl/ucopy_cpu.sv
module ucopy_cpu
  import ucopy_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int OPC_W  = 4,
  parameter int CAR_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [OPC_W+3*ADDR_W-1:0]   instrIn,
  output logic                        ready,
  output logic [ADDR_W-1:0]           memAddr,
  input  logic [DATA_W-1:0]           memRdata,
  output logic [DATA_W-1:0]           memWdata,
  output logic                        memWe
);
  dpStrobes_t       strobes;
  logic [OPC_W-1:0] opcode;

  ucopy_ctrl #(.CAR_W(CAR_W), .OPC_W(OPC_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode),
    .strobes(strobes), .ready(ready)
  );

  ucopy_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .instrIn(instrIn),
    .memRdata(memRdata), .opcode(opcode), .memAddr(memAddr),
    .memWdata(memWdata), .memWe(memWe)
  );
endmodule

// File: rtl/ucopy_cpu_chk.sv
module ucopy_cpu_chk #(
  parameter int INSTR_W = 16,
  parameter int OPC_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [INSTR_W-1:0] instrIn,
  input logic               ready,
  input logic               memWe
);
  logic isCopy;
  assign isCopy = (instrIn[INSTR_W-1 -: OPC_W] == OPC_W'(ucopy_pkg::OPC_COPY));

  AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    memWe |=> !memWe); // R5
  AST_WRITE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    memWe |-> (!ready && $past(!ready) && $past(!ready, 2) && $past(!ready, 3))); // R3
  AST_IDLE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    memWe |=> ready); // R3
  AST_COPY_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (ready && start && isCopy) |=> !ready); // R3
  AST_OTHER_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ready && start && !isCopy) |=> ready); // R6
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ready |-> !memWe); // R6
endmodule

bind ucopy_cpu ucopy_cpu_chk #(.INSTR_W(OPC_W + 3 * ADDR_W), .OPC_W(OPC_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .instrIn(instrIn),
  .ready(ready), .memWe(memWe)
);

// File: tb/ucopy_cpu_bench.sv
module ucopy_cpu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instrIn = '0;
  logic        ready;
  logic [3:0]  memAddr;
  logic [15:0] memRdata;
  logic [15:0] memWdata;
  logic        memWe;

  int checks = 0;
  int failures = 0;

  logic [15:0] ram    [16];
  logic [15:0] refMem [16];

  typedef struct packed { logic [3:0] addr; logic [15:0] data; } wrItem_t;
  wrItem_t expQ[$];

  always #2.5 clk = ~clk;

  ucopy_cpu u_ucopy_cpu (
    .clk(clk), .rst(rst), .start(start), .instrIn(instrIn), .ready(ready),
    .memAddr(memAddr), .memRdata(memRdata), .memWdata(memWdata), .memWe(memWe)
  );

  assign memRdata = ram[memAddr];
  always_ff @(posedge clk) if (memWe) ram[memAddr] <= memWdata;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: every write pops one expected item (R5).
  always @(negedge clk) begin
    if (!rst && memWe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "unexpected write addr", 32'(memAddr), 32'hFFFF);
      end else begin
        wrItem_t e;
        e = expQ.pop_front();
        check(memAddr == e.addr, "R5", "write addr", 32'(memAddr), 32'(e.addr));
        check(memWdata == e.data, "R5", "write data", 32'(memWdata), 32'(e.data));
      end
    end
  end

  // Driver: issue one instruction, optionally stray start or garbage instr mid-run.
  task automatic runOp(input logic [15:0] ins, input bit stray, input bit garble);
    int cnt;
    bit isCopy;
    isCopy = (ins[15:12] == 4'h2);
    check(ready == 1'b1, "R9", "ready before start", 32'(ready), 32'd1);
    if (isCopy) begin
      expQ.push_back('{addr: ins[11:8], data: refMem[ins[7:4]]});
      refMem[ins[11:8]] = refMem[ins[7:4]];
    end
    start = 1'b1;
    instrIn = ins;
    @(negedge clk);
    start = 1'b0;
    if (garble) instrIn = ~ins ^ 16'h5A5A; // R7
    cnt = 0;
    while (!ready && cnt < 20) begin
      cnt++;
      if (cnt == 1 && stray) begin start = 1'b1; instrIn = 16'h2F0F; end // R8
      if (cnt == 2) begin
        start = 1'b0;
        check(memAddr == ins[7:4] && !memWe, "R4", "read addr", 32'(memAddr), 32'(ins[7:4]));
      end
      if (cnt == 4) check(memWe == 1'b1, "R5", "we in step 4", 32'(memWe), 32'd1);
      @(negedge clk);
    end
    start = 1'b0;
    if (isCopy) check(cnt == 4, "R3", "busy length", 32'(cnt), 32'd4);
    else        check(cnt == 0, "R6", "no busy for other opcode", 32'(cnt), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      ram[i] = 16'h1000 + 16'(i * 16'h0111);
      refMem[i] = ram[i];
    end
    @(negedge clk);
    check(ready == 1'b1 && memWe == 1'b0 && memAddr == 4'h0, "R1", "reset outputs",
          {ready, memWe, 26'd0, memAddr}, 32'h8000_0000);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ready == 1'b1 && memWe == 1'b0, "R1", "after reset", 32'(ready), 32'd1);

    runOp(16'h2021, 1'b0, 1'b0);            // R2 R3 basic copy M[2]->M[0]
    runOp(16'h2F3A, 1'b0, 1'b1);            // R7 garbled instrIn mid-run
    runOp(16'h2450, 1'b1, 1'b0);            // R8 stray start while busy
    runOp(16'h2545, 1'b0, 1'b0);            // R9 back to back, A==B... different: 5<-4
    runOp(16'h2777, 1'b0, 1'b0);            // self copy
    runOp(16'h1234, 1'b0, 1'b0);            // R6
    runOp(16'hF0E1, 1'b0, 1'b0);            // R6
    runOp(16'h0000, 1'b0, 1'b0);            // R6
    runOp(16'h2E0F, 1'b0, 1'b0);            // R2 extreme fields

    // R10: reset mid-program aborts the copy.
    start = 1'b1; instrIn = 16'h2C0D;
    @(negedge clk);
    start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(ready == 1'b1, "R10", "ready after abort", 32'(ready), 32'd1);
    repeat (6) @(negedge clk);
    check(ready == 1'b1 && memWe == 1'b0, "R10", "still idle", 32'(ready), 32'd1);

    for (int i = 0; i < 16; i++)
      check(ram[i] == refMem[i], "R5", $sformatf("ram[%0d]", i), 32'(ram[i]), 32'(refMem[i]));
    check(expQ.size() == 0, "R5", "pending writes", 32'(expQ.size()), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R3 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule